// File: doc/BRIEF.md
# Cascadable Bit-Slice Arithmetic/Logic Stage

This block is the combinational arithmetic and logic stage of a narrow slice that can be chained into wider words. A 3-bit source code chooses an operand pair (R, S) from two register read values, a direct data input, an auxiliary holding-register value and the constant zero. A 3-bit function code then applies one of three arithmetic or five bitwise operations to that pair, with an active-high carry input taking part in the arithmetic ones.

Besides the result, the stage reports a carry-out, active-low group generate and propagate terms for an external lookahead unit, a two's-complement overflow flag, a zero flag and the sign bit. Register storage, shifting and output drivers sit around this stage and are not part of it. The slice width is a parameter with a default of 4 bits.

Top module: `alu_slice`

## Requirements
- R1: The source code selects (R,S) as: 0=(A,Q), 1=(A,B), 2=(0,Q), 3=(0,B), 4=(0,A), 5=(D,A), 6=(D,Q), 7=(D,0), where A, B, D, Q are the inputs `a_port`, `b_port`, `d_in`, `q_in`.
- R2: Function code 0 gives F = (R + S + cin) mod 2^W, and `cout` is bit W of that sum.
- R3: Function code 1 gives F = (S + ~R + cin) mod 2^W, so cin=1 yields S−R and cin=0 yields S−R−1; `cout` is bit W of that sum.
- R4: Function code 2 gives F = (R + ~S + cin) mod 2^W, so cin=1 yields R−S and cin=0 yields R−S−1; `cout` is bit W of that sum.
- R5: Function codes 3..7 give F = R|S, R&S, (~R)&S, R^S, ~(R^S) respectively, and `cin` has no effect on F in these codes.
- R6: In the arithmetic codes `ovr` is high exactly when the carry into the top bit differs from the carry out of it.
- R7: `zero` is high exactly when all bits of F are low.
- R8: `sign` equals the top bit of F.
- R9: With X, Y the adder operands after any inversion, `gen_n` is low exactly when X + Y with no carry-in overflows W bits, `prop_n` is low exactly when every bit of X|Y is set, and `cout` = ~gen_n | (~prop_n & cin).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_code | input | 3 | Operand pair select |
| fn_code | input | 3 | Operation select |
| cin | input | 1 | Carry into the least significant bit, active high |
| a_port | input | W | First register read value |
| b_port | input | W | Second register read value |
| d_in | input | W | Direct data input |
| q_in | input | W | Holding-register value |
| f_out | output | W | Result |
| cout | output | 1 | Carry out of the most significant bit, active high |
| gen_n | output | 1 | Group carry generate, active low |
| prop_n | output | 1 | Group carry propagate, active low |
| ovr | output | 1 | Two's-complement overflow |
| zero | output | 1 | Result is all zeros |
| sign | output | 1 | Top bit of the result |

## Verification
The assertions check on every input change that the carry-out agrees with the group generate and propagate terms and the carry-in, that the zero and sign flags match the result, and, for a few fixed source codes, that addition, full subtraction, overflow and plain passes of A, D and Q give the arithmetically expected values. Only the bench's sweep over every source code, every function code, both carry-in values and all A/B combinations shows that the whole pairing table and every operation are right, that subtraction with a low carry-in is one less, and that the carry-in leaves the logic results untouched.

// File: rtl/alu_slice_pkg.sv
// Package: alu_slice_pkg
// Shared encodings for the slice arithmetic/logic stage.
// Assumes the source and function codes are 3 bits wide each.
package alu_slice_pkg;

    // Operand pair selection, (R,S)
    typedef enum logic [2:0] {
        SRC_A_Q = 3'd0,
        SRC_A_B = 3'd1,
        SRC_Z_Q = 3'd2,
        SRC_Z_B = 3'd3,
        SRC_Z_A = 3'd4,
        SRC_D_A = 3'd5,
        SRC_D_Q = 3'd6,
        SRC_D_Z = 3'd7
    } src_pair_e;

    // Operation selection
    typedef enum logic [2:0] {
        FN_ADD      = 3'd0,
        FN_S_SUB_R  = 3'd1,
        FN_R_SUB_S  = 3'd2,
        FN_OR       = 3'd3,
        FN_AND      = 3'd4,
        FN_NR_AND_S = 3'd5,
        FN_XOR      = 3'd6,
        FN_XNOR     = 3'd7
    } alu_fn_e;

    // Which adder operand, if any, is inverted
    typedef enum logic [1:0] {
        INV_NONE = 2'd0,
        INV_R    = 2'd1,
        INV_S    = 2'd2
    } inv_sel_e;

    // True for the three arithmetic operations
    function automatic logic fn_is_arith(input alu_fn_e fn);
        return (fn == FN_ADD) || (fn == FN_S_SUB_R) || (fn == FN_R_SUB_S);
    endfunction

    // Operand inversion needed by an operation
    function automatic inv_sel_e fn_inversion(input alu_fn_e fn);
        case (fn)
            FN_S_SUB_R: return INV_R;
            FN_R_SUB_S: return INV_S;
            default:    return INV_NONE;
        endcase
    endfunction

endpackage

// File: rtl/slice_operand_mux.sv
// Module: slice_operand_mux
// Picks the (R,S) operand pair from A, B, D, Q and zero by source code.
// Assumes all data inputs share the slice width W.
module slice_operand_mux
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  src_pair_e      src,
    input  logic [W-1:0]   a_val,
    input  logic [W-1:0]   b_val,
    input  logic [W-1:0]   d_val,
    input  logic [W-1:0]   q_val,
    output logic [W-1:0]   r_op,
    output logic [W-1:0]   s_op
);

    localparam logic [W-1:0] ZERO = '0;

    // Operand pairing table
    always_comb begin
        case (src)
            SRC_A_Q: begin r_op = a_val; s_op = q_val; end
            SRC_A_B: begin r_op = a_val; s_op = b_val; end
            SRC_Z_Q: begin r_op = ZERO;  s_op = q_val; end
            SRC_Z_B: begin r_op = ZERO;  s_op = b_val; end
            SRC_Z_A: begin r_op = ZERO;  s_op = a_val; end
            SRC_D_A: begin r_op = d_val; s_op = a_val; end
            SRC_D_Q: begin r_op = d_val; s_op = q_val; end
            SRC_D_Z: begin r_op = d_val; s_op = ZERO;  end
            default: begin r_op = ZERO;  s_op = ZERO;  end
        endcase
    end

endmodule

// File: rtl/slice_carry_chain.sv
// Module: slice_carry_chain
// Adds R and S, with one of them optionally inverted, plus a carry-in.
// Produces the sum, the carry into and out of the top bit, and
// active-low group generate/propagate over the post-inversion operands.
// Assumes W >= 2.
module slice_carry_chain
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] r_op,
    input  logic [W-1:0] s_op,
    input  inv_sel_e     inv,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_msb_in,
    output logic         c_out,
    output logic         grp_gen_n,
    output logic         grp_prop_n
);

    localparam int MSB = W - 1;

    logic [W-1:0] x_op;
    logic [W-1:0] y_op;
    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] carry_at;

    // Apply the operand inversion requested by the operation
    always_comb begin
        x_op = (inv == INV_R) ? ~r_op : r_op;
        y_op = (inv == INV_S) ? ~s_op : s_op;
    end

    // Per-bit generate and propagate terms
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit_terms
            assign bit_gen[gi]  = x_op[gi] & y_op[gi];
            assign bit_prop[gi] = x_op[gi] | y_op[gi];
        end
    endgenerate

    // Ripple carry through the slice and form the sum bits
    always_comb begin
        logic carry;
        carry = cin;
        for (int i = 0; i < W; i++) begin
            carry_at[i] = carry;
            sum[i]      = x_op[i] ^ y_op[i] ^ carry;
            carry       = bit_gen[i] | (bit_prop[i] & carry);
        end
        c_out = carry;
    end

    assign c_msb_in = carry_at[MSB];

    // Group lookahead terms, independent of the carry-in
    always_comb begin
        logic gg;
        gg = 1'b0;
        for (int i = 0; i < W; i++) begin
            gg = bit_gen[i] | (bit_prop[i] & gg);
        end
        grp_gen_n  = ~gg;
        grp_prop_n = ~(&bit_prop);
    end

endmodule

// File: rtl/slice_logic_unit.sv
// Module: slice_logic_unit
// Bitwise operations on R and S for the five logic function codes.
// Assumes the arithmetic codes are handled elsewhere; returns zero for them.
module slice_logic_unit
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  alu_fn_e      fn,
    input  logic [W-1:0] r_op,
    input  logic [W-1:0] s_op,
    output logic [W-1:0] f_logic
);

    // Bitwise operation select
    always_comb begin
        case (fn)
            FN_OR:       f_logic = r_op | s_op;
            FN_AND:      f_logic = r_op & s_op;
            FN_NR_AND_S: f_logic = ~r_op & s_op;
            FN_XOR:      f_logic = r_op ^ s_op;
            FN_XNOR:     f_logic = ~(r_op ^ s_op);
            default:     f_logic = '0;
        endcase
    end

endmodule

// File: rtl/slice_flags.sv
// Module: slice_flags
// Status flags derived from the result and the top-bit carries.
// Assumes the carries come from the same adder path for every code.
module slice_flags #(
    parameter int W = 4
) (
    input  logic [W-1:0] f_val,
    input  logic         c_msb_in,
    input  logic         c_out,
    output logic         zero,
    output logic         sign,
    output logic         ovr
);

    // Zero detect, sign and overflow
    always_comb begin
        zero = ~|f_val;
        sign = f_val[W-1];
        ovr  = c_msb_in ^ c_out;
    end

endmodule

// File: rtl/alu_slice.sv
// Module: alu_slice
// Combinational arithmetic/logic stage of a cascadable W-bit slice.
// Selects an operand pair, performs one of eight operations and reports
// carry, lookahead, overflow, zero and sign. Purely combinational; it
// assumes storage and shifting are done by the surrounding logic.
module alu_slice
    import alu_slice_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [2:0]   src_code,
    input  logic [2:0]   fn_code,
    input  logic         cin,
    input  logic [W-1:0] a_port,
    input  logic [W-1:0] b_port,
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] q_in,
    output logic [W-1:0] f_out,
    output logic         cout,
    output logic         gen_n,
    output logic         prop_n,
    output logic         ovr,
    output logic         zero,
    output logic         sign
);

    src_pair_e    src;
    alu_fn_e      fn;
    inv_sel_e     inv;
    logic [W-1:0] r_op;
    logic [W-1:0] s_op;
    logic [W-1:0] sum;
    logic [W-1:0] f_logic;
    logic         c_msb_in;

    // Decode the control codes
    always_comb begin
        src = src_pair_e'(src_code);
        fn  = alu_fn_e'(fn_code);
        inv = fn_inversion(fn);
    end

    slice_operand_mux #(.W(W)) u_mux (
        .src   (src),
        .a_val (a_port),
        .b_val (b_port),
        .d_val (d_in),
        .q_val (q_in),
        .r_op  (r_op),
        .s_op  (s_op)
    );

    slice_carry_chain #(.W(W)) u_chain (
        .r_op       (r_op),
        .s_op       (s_op),
        .inv        (inv),
        .cin        (cin),
        .sum        (sum),
        .c_msb_in   (c_msb_in),
        .c_out      (cout),
        .grp_gen_n  (gen_n),
        .grp_prop_n (prop_n)
    );

    slice_logic_unit #(.W(W)) u_logic (
        .fn      (fn),
        .r_op    (r_op),
        .s_op    (s_op),
        .f_logic (f_logic)
    );

    // Result select between adder and logic unit
    always_comb begin
        f_out = fn_is_arith(fn) ? sum : f_logic;
    end

    slice_flags #(.W(W)) u_flags (
        .f_val    (f_out),
        .c_msb_in (c_msb_in),
        .c_out    (cout),
        .zero     (zero),
        .sign     (sign),
        .ovr      (ovr)
    );

endmodule

// File: rtl/alu_slice_checker.sv
// Module: alu_slice_checker
// Immediate assertions on the slice ports, evaluated on every change.
// The stage has no clock, so all checks are combinational.
module alu_slice_checker #(
    parameter int W = 4
) (
    input logic [2:0]   src_code,
    input logic [2:0]   fn_code,
    input logic         cin,
    input logic [W-1:0] a_port,
    input logic [W-1:0] b_port,
    input logic [W-1:0] d_in,
    input logic [W-1:0] q_in,
    input logic [W-1:0] f_out,
    input logic         cout,
    input logic         gen_n,
    input logic         prop_n,
    input logic         ovr,
    input logic         zero,
    input logic         sign
);

    localparam int MSB = W - 1;

    logic [W:0] ab_total;

    // Reference sum of A and B with carry
    always_comb begin
        ab_total = {1'b0, a_port} + {1'b0, b_port} + {{W{1'b0}}, cin};
    end

    // Port-level property checks
    always_comb begin
        AST_LOOKAHEAD_CARRY: assert (cout == (~gen_n | (~prop_n & cin)))
            else $error("carry-out disagrees with generate/propagate"); // R9
        AST_ZERO_FLAG: assert (zero == (f_out == '0))
            else $error("zero flag wrong"); // R7
        AST_SIGN_BIT: assert (sign == f_out[MSB])
            else $error("sign flag wrong"); // R8
        if (src_code == 3'd1 && fn_code == 3'd0) begin
            AST_ADD_A_B: assert ({cout, f_out} == ab_total)
                else $error("A plus B wrong"); // R2
            AST_OVERFLOW_ADD: assert (ovr == ((a_port[MSB] == b_port[MSB]) && (f_out[MSB] != a_port[MSB])))
                else $error("overflow wrong on addition"); // R6
        end
        if (src_code == 3'd1 && fn_code == 3'd1 && cin) begin
            AST_SUB_FULL: assert (f_out == W'(b_port - a_port))
                else $error("B minus A wrong"); // R3
        end
        if (src_code == 3'd4 && fn_code == 3'd3) begin
            AST_PASS_A: assert (f_out == a_port)
                else $error("zero OR A wrong"); // R1
        end
        if (src_code == 3'd7 && fn_code == 3'd3) begin
            AST_PASS_D: assert (f_out == d_in)
                else $error("D OR zero wrong"); // R1
        end
        if (src_code == 3'd2 && fn_code == 3'd0 && !cin) begin
            AST_PASS_Q: assert (f_out == q_in)
                else $error("zero plus Q wrong"); // R2
        end
    end

endmodule

bind alu_slice alu_slice_checker #(.W(W)) u_chk (
    .src_code (src_code),
    .fn_code  (fn_code),
    .cin      (cin),
    .a_port   (a_port),
    .b_port   (b_port),
    .d_in     (d_in),
    .q_in     (q_in),
    .f_out    (f_out),
    .cout     (cout),
    .gen_n    (gen_n),
    .prop_n   (prop_n),
    .ovr      (ovr),
    .zero     (zero),
    .sign     (sign)
);

// File: tb/sim_alu_slice.sv
// Bench: sweeps every source code, function code and carry-in over all
// A/B combinations, with D and Q derived, and checks against an
// arithmetic model.
module sim_alu_slice;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic [2:0]   src_code = '0;
    logic [2:0]   fn_code = '0;
    logic         cin = 1'b0;
    logic [W-1:0] a_port = '0;
    logic [W-1:0] b_port = '0;
    logic [W-1:0] d_in = '0;
    logic [W-1:0] q_in = '0;
    logic [W-1:0] f_out;
    logic         cout, gen_n, prop_n, ovr, zero, sign;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    int er, es, ex, ey, tot, ef, c3, eco, egen, eprop;
    string tag;

    always #5 clk = ~clk;

    alu_slice #(.W(W)) u0 (
        .src_code (src_code),
        .fn_code  (fn_code),
        .cin      (cin),
        .a_port   (a_port),
        .b_port   (b_port),
        .d_in     (d_in),
        .q_in     (q_in),
        .f_out    (f_out),
        .cout     (cout),
        .gen_n    (gen_n),
        .prop_n   (prop_n),
        .ovr      (ovr),
        .zero     (zero),
        .sign     (sign)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d (src=%0d fn=%0d cin=%0d a=%0d b=%0d d=%0d q=%0d)",
                     req, what, act, exp, src_code, fn_code, cin, a_port, b_port, d_in, q_in);
        end
    endtask

    initial begin
        for (int sc = 0; sc < 8; sc++) begin
            for (int fc = 0; fc < 8; fc++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int v = 0; v < 256; v++) begin
                        @(posedge clk);
                        src_code = 3'(sc);
                        fn_code  = 3'(fc);
                        cin      = ci[0];
                        a_port   = 4'(v & 15);
                        b_port   = 4'(v >> 4);
                        d_in     = 4'(((v & 15) + 3 * (v >> 4)) & 15);
                        q_in     = 4'((((v & 15) * 5) ^ (v >> 4) ^ 9) & 15);
                        @(negedge clk);
                        // R1: operand pairing model
                        case (sc)
                            0: begin er = int'(a_port); es = int'(q_in);   end
                            1: begin er = int'(a_port); es = int'(b_port); end
                            2: begin er = 0;            es = int'(q_in);   end
                            3: begin er = 0;            es = int'(b_port); end
                            4: begin er = 0;            es = int'(a_port); end
                            5: begin er = int'(d_in);   es = int'(a_port); end
                            6: begin er = int'(d_in);   es = int'(q_in);   end
                            default: begin er = int'(d_in); es = 0;        end
                        endcase
                        if (fc < 3) begin
                            ex = (fc == 1) ? (15 - er) : er;
                            ey = (fc == 2) ? (15 - es) : es;
                            tot   = ex + ey + ci;
                            ef    = tot % 16;
                            eco   = tot / 16;
                            c3    = ((ex % 8) + (ey % 8) + ci) / 8;
                            egen  = (ex + ey) / 16;
                            eprop = ((ex | ey) == 15) ? 1 : 0;
                            tag = (fc == 0) ? "R2" : (fc == 1) ? "R3" : "R4";
                            check(tag, "f_out (R1 pairing)", int'(f_out), ef);
                            check(tag, "cout", int'(cout), eco);
                            check("R6", "ovr", int'(ovr), c3 ^ eco);
                            check("R9", "gen_n", int'(gen_n), 1 - egen);
                            check("R9", "prop_n", int'(prop_n), 1 - eprop);
                        end else begin
                            case (fc)
                                3: ef = er | es;
                                4: ef = er & es;
                                5: ef = (15 - er) & es;
                                6: ef = er ^ es;
                                default: ef = 15 - (er ^ es);
                            endcase
                            // R5: model ignores cin, both cin values swept
                            check("R5", "f_out logic (R1 pairing)", int'(f_out), ef);
                        end
                        check("R7", "zero", int'(zero), (ef == 0) ? 1 : 0);
                        check("R8", "sign", int'(sign), ef / 8);
                    end
                end
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule